// File: doc/BRIEF.md
# Framing Loss-of-Sync Monitor

This block watches a periodic framing pulse on a serial data clock and decides whether the pulse arrives on time. The number of clock cycles between two rising framing edges should match the frame length. The frame length follows from the programmed slot count: eight bits per slot, and twice that in double clock mode. The block keeps a status bit that says whether framing is synchronized. It also emits a one-cycle interrupt request each time that status changes.

The hysteresis is deliberately asymmetric. Two consecutive frames of correct length, by default, move the monitor into the synchronized state. One wrong period takes it out again. A period that runs long is flagged in the very clock cycle its length passes the expected value, so the monitor does not wait for the late edge. The framing pulse is assumed to repeat once per frame. Interrupt masking and any host access live outside this block.

Top module: `frame_sync_monitor`

## Requirements
- R1: The expected period is slot_count × 8 clock cycles when `dbl_rate_i` is 0, and slot_count × 16 when it is 1. The value is taken from the inputs as they stand when the period is judged.
- R2: A period is the number of clock cycles between two consecutive rising edges of `frame_i`. A period exactly equal to the expected value is good. The first rising edge after reset only starts timing and judges nothing.
- R3: While unsynchronized, `in_sync_o` rises after two consecutive good periods, in the clock cycle that ends the second one.
- R4: While synchronized, a framing edge that closes a period shorter than expected clears `in_sync_o` in that clock cycle.
- R5: If no framing edge has arrived when the count since the last edge reaches the expected value, that period is bad at once. `in_sync_o` then clears in that clock cycle, which is exactly the expected number of cycles after the last edge.
- R6: Any bad period, short or long, discards the progress made so far toward gaining synchronization.
- R7: `irq_o` is high for exactly one clock cycle in the same cycle that `in_sync_o` changes value, and is low in every other cycle.
- R8: While `rst_n` is low and after it is released, `in_sync_o` is 0. Neither entering nor leaving reset raises `irq_o`.
- R9: After a long period has been flagged, the late framing edge is not judged again. It starts a fresh period, and that fresh period can count as the first good one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_i | input | 1 | Framing pulse, sampled on the clock; its rising edge marks a frame start |
| slots_i | input | SLOT_W | Programmed number of slots per frame |
| dbl_rate_i | input | 1 | 1 selects two clocks per bit |
| in_sync_o | output | 1 | Synchronization status, 1 when synchronized |
| irq_o | output | 1 | One-cycle pulse on every status change |

## Verification
The bench builds the block with its default parameters. These allow slot counts up to 128 and require two good periods to gain synchronization. The counter is therefore 12 bits wide, so the largest frame of 128 slots in double clock mode (2048 cycles) fits, and the bench runs exactly that frame length. At the low end, 4 slots in single mode gives 32-cycle frames. These keep the stimulus table short enough to cover gain, short-period loss, early long-period loss, mode changes while synchronized, and counter clearing while unsynchronized.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

   typedef enum logic {
      SYNC_OFF = 1'b0,
      SYNC_ON  = 1'b1
   } sync_state_e;

   // Clock cycles per frame: eight bits per slot, doubled in double rate mode.
   function automatic int unsigned frame_cycles(input int unsigned slots, input bit dbl);
      return dbl ? slots * 16 : slots * 8;
   endfunction

endpackage

// File: rtl/lsm_edge_detect.sv
module lsm_edge_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic level_i,
   output logic rise_o
);

   logic level_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_q <= 1'b0;
      else        level_q <= level_i;
   end

   assign rise_o = level_i & ~level_q;

endmodule

// File: rtl/lsm_period_timer.sv
module lsm_period_timer #(
   parameter int unsigned SLOT_W = 8,
   parameter int unsigned CNT_W  = SLOT_W + 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rise_i,
   input  logic [SLOT_W-1:0] slots_i,
   input  logic              dbl_rate_i,
   output logic              good_o,
   output logic              bad_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   generate
      if (CNT_W < SLOT_W + 4) begin : g_width_chk
         $error("lsm_period_timer: CNT_W too small for SLOT_W");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] target;
   logic             armed_q;
   logic             overrun;
   logic             at_edge_ok;

   assign target     = dbl_rate_i ? (CNT_W'(slots_i) << 4) : (CNT_W'(slots_i) << 3);
   assign overrun    = armed_q & ~rise_i & (cnt_q >= target);
   assign at_edge_ok = cnt_q == target;
   assign good_o     = rise_i & armed_q & at_edge_ok;
   assign bad_o      = (rise_i & armed_q & ~at_edge_ok) | overrun;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (rise_i) begin
         cnt_q   <= CNT_W'(1);
         armed_q <= 1'b1;
      end else begin
         if (cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         if (overrun)          armed_q <= 1'b0;
      end
   end

   AST_GOOD_BAD_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({good_o, bad_o}));                                       // R2
   AST_EDGE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |=> (cnt_q == CNT_W'(1)));                                  // R2
   AST_LATE_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
      (bad_o && !rise_i) |=> !bad_o);                                    // R9

endmodule

// File: rtl/lsm_sync_fsm.sv
module lsm_sync_fsm
   import lsm_pkg::*;
#(
   parameter int unsigned GAIN_FRAMES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic good_i,
   input  logic bad_i,
   output logic in_sync_o,
   output logic irq_o
);

   localparam int unsigned GCNT_W = (GAIN_FRAMES > 1) ? $clog2(GAIN_FRAMES) : 1;

   sync_state_e state_q, state_nx;
   logic        gain_now;

   generate
      if (GAIN_FRAMES < 1) begin : g_gain_chk
         $error("lsm_sync_fsm: GAIN_FRAMES must be at least 1");
      end
      if (GAIN_FRAMES == 1) begin : g_gain_single
         assign gain_now = good_i;
      end else begin : g_gain_count
         logic [GCNT_W-1:0] gcnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          gcnt_q <= '0;
            else if (bad_i || state_q == SYNC_ON) gcnt_q <= '0;
            else if (good_i)                     gcnt_q <= gain_now ? '0 : gcnt_q + 1'b1;
         end
         assign gain_now = good_i && (gcnt_q == GCNT_W'(GAIN_FRAMES - 1));
      end
   endgenerate

   always_comb begin
      state_nx = state_q;
      case (state_q)
         SYNC_OFF: if (gain_now) state_nx = SYNC_ON;
         SYNC_ON:  if (bad_i)    state_nx = SYNC_OFF;
         default:                state_nx = SYNC_OFF;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SYNC_OFF;
         irq_o   <= 1'b0;
      end else begin
         state_q <= state_nx;
         irq_o   <= state_nx != state_q;
      end
   end

   assign in_sync_o = state_q == SYNC_ON;

   AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);                                                 // R7
   AST_RISE_NEEDS_GOOD: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_sync_o && !good_i) |=> !in_sync_o);                           // R3
   AST_BAD_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      bad_i |=> !in_sync_o);                                             // R4
   AST_CHANGE_HAS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (in_sync_o != $past(in_sync_o)) |-> irq_o);                        // R7

endmodule

// File: rtl/frame_sync_monitor.sv
module frame_sync_monitor #(
   parameter int unsigned MAX_SLOTS   = 128,
   parameter int unsigned GAIN_FRAMES = 2,
   parameter int unsigned SLOT_W      = $clog2(MAX_SLOTS + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_i,
   input  logic [SLOT_W-1:0] slots_i,
   input  logic              dbl_rate_i,
   output logic              in_sync_o,
   output logic              irq_o
);

   localparam int unsigned CNT_W = SLOT_W + 4;

   generate
      if (MAX_SLOTS < 4) begin : g_slots_chk
         $error("frame_sync_monitor: MAX_SLOTS must be at least 4");
      end
   endgenerate

   logic frame_rise;
   logic period_good;
   logic period_bad;

   lsm_edge_detect u_edge (
      .clk     (clk),
      .rst_n   (rst_n),
      .level_i (frame_i),
      .rise_o  (frame_rise)
   );

   lsm_period_timer #(
      .SLOT_W (SLOT_W),
      .CNT_W  (CNT_W)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .rise_i     (frame_rise),
      .slots_i    (slots_i),
      .dbl_rate_i (dbl_rate_i),
      .good_o     (period_good),
      .bad_o      (period_bad)
   );

   lsm_sync_fsm #(
      .GAIN_FRAMES (GAIN_FRAMES)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .good_i    (period_good),
      .bad_i     (period_bad),
      .in_sync_o (in_sync_o),
      .irq_o     (irq_o)
   );

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!in_sync_o && !irq_o));                                // R8

endmodule

// File: tb/sim_frame_sync_monitor.sv
module sim_frame_sync_monitor;

   localparam int SW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          frame_i = 1'b0;
   logic [SW-1:0] slots_i = 8'd4;
   logic          dbl_rate_i = 1'b0;
   logic          in_sync_o;
   logic          irq_o;

   int n_chk = 0;
   int n_bad = 0;
   int irqs  = 0;

   always #10 clk = ~clk;

   frame_sync_monitor u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_i    (frame_i),
      .slots_i    (slots_i),
      .dbl_rate_i (dbl_rate_i),
      .in_sync_o  (in_sync_o),
      .irq_o      (irq_o)
   );

   // {slots, dbl, period, expected in_sync, expected irq count}
   localparam int NV = 19;
   localparam logic [27:0] VEC [0:NV-1] = '{
      {8'd4,  1'b0, 16'd32,  1'b0, 2'd0},  // R2 first edge arms only
      {8'd4,  1'b0, 16'd32,  1'b0, 2'd0},  // R3 one good
      {8'd4,  1'b0, 16'd32,  1'b1, 2'd1},  // R3 second good gains
      {8'd4,  1'b0, 16'd32,  1'b1, 2'd0},  // R7 no change no irq
      {8'd4,  1'b0, 16'd31,  1'b0, 2'd1},  // R4 short loses
      {8'd4,  1'b0, 16'd32,  1'b0, 2'd0},  // R6 one good
      {8'd4,  1'b0, 16'd33,  1'b0, 2'd0},  // R6 long clears progress
      {8'd4,  1'b0, 16'd32,  1'b0, 2'd0},  // R9 fresh period good
      {8'd4,  1'b0, 16'd32,  1'b1, 2'd1},  // R9 gains again
      {8'd4,  1'b0, 16'd40,  1'b0, 2'd1},  // R5 long loses, single irq
      {8'd4,  1'b1, 16'd64,  1'b0, 2'd0},  // R1 double rate good
      {8'd4,  1'b1, 16'd64,  1'b1, 2'd1},  // R1 gains in double rate
      {8'd8,  1'b0, 16'd64,  1'b1, 2'd0},  // R1 same length other setting
      {8'd8,  1'b1, 16'd128, 1'b1, 2'd0},  // R1 mode change held
      {8'd8,  1'b1, 16'd127, 1'b0, 2'd1},  // R4 one clock missing
      {8'd16, 1'b0, 16'd128, 1'b0, 2'd0},  // R6 one good
      {8'd16, 1'b0, 16'd64,  1'b0, 2'd0},  // R6 short clears progress
      {8'd16, 1'b0, 16'd128, 1'b0, 2'd0},  // R6 one good again
      {8'd16, 1'b0, 16'd128, 1'b1, 2'd1}   // R3 gains
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Rising framing edge len cycles after the previous one; ends one
   // negedge after the judging clock edge, with irq pulses counted.
   task automatic gap(input int len);
      irqs = 0;
      for (int i = 0; i < len - 1; i++) begin
         @(negedge clk);
         irqs += int'(irq_o);
         frame_i = (i == len - 2);
      end
      @(negedge clk);
      irqs += int'(irq_o);
      frame_i = 1'b0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      // R8 reset state
      repeat (3) @(negedge clk);
      check("R8 in_sync in reset", int'(in_sync_o), 0);
      check("R8 irq in reset", int'(irq_o), 0);
      rst_n = 1'b1;
      irqs = 0;
      repeat (4) begin
         @(negedge clk);
         irqs += int'(irq_o);
      end
      check("R8 in_sync after release", int'(in_sync_o), 0);
      check("R8 no irq after release", irqs, 0);

      // table walk
      for (int v = 0; v < NV; v++) begin
         slots_i    = VEC[v][27:20];
         dbl_rate_i = VEC[v][19];
         gap(int'(VEC[v][18:3]));
         check($sformatf("R1-table %0d in_sync", v), int'(in_sync_o), int'(VEC[v][2]));
         check($sformatf("R7 table %0d irq count", v), irqs, int'(VEC[v][1:0]));
      end

      // R5 early loss: synced at 16 slots single (128 cycles), framing stops
      begin
         int n;
         n = 0;
         for (int k = 1; k <= 300; k++) begin
            @(negedge clk);
            if (!in_sync_o) begin
               n = k;
               break;
            end
         end
         check("R5 cycles to loss", n, 128);
         check("R5 irq at loss", int'(irq_o), 1);
         @(negedge clk);
         check("R7 irq one cycle", int'(irq_o), 0);
      end

      // R1 largest frame: 128 slots double rate = 2048 cycles
      slots_i    = 8'd128;
      dbl_rate_i = 1'b1;
      gap(2048);
      check("R2 max arm in_sync", int'(in_sync_o), 0);
      gap(2048);
      check("R1 max one good in_sync", int'(in_sync_o), 0);
      gap(2048);
      check("R1 max gain in_sync", int'(in_sync_o), 1);
      check("R1 max gain irq", irqs, 1);

      // R8 reset while synced: no irq
      rst_n = 1'b0;
      irqs = 0;
      repeat (2) begin
         @(negedge clk);
         irqs += int'(irq_o);
      end
      check("R8 reset clears in_sync", int'(in_sync_o), 0);
      rst_n = 1'b1;
      repeat (3) begin
         @(negedge clk);
         irqs += int'(irq_o);
      end
      check("R8 no irq around reset", irqs, 0);
      check("R8 in_sync stays low", int'(in_sync_o), 0);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule